// File: doc/BRIEF.md
# Masked External Event Trigger Unit

This block watches a 16-bit external event bus and decides when a pattern run starts and when it should hold. Three comparators each test the bus against a stored event value, and a companion mask names the bits that do not take part in the comparison. Two of them (a "first" condition and a "second" condition) form the start trigger. They can be required together in one cycle (concurrent mode), or the first must be seen before the second (sequential mode). The third comparator drives a pause level while the sequencer reports that it is running. A pause can also be forced for as long as the run lasts.

Software programs the unit through a write-only address/data port. An emulation register on that same port can stand in for the live bus. This lets a test program be exercised with no external hardware attached. The live bus is resynchronised into the local clock domain before any comparison is made. The trigger is a one-cycle pulse, and the unit fires once per arming.

Top module: `evt_trigger_unit`

## Requirements
- R1: After reset, trig_pulse, pause, armed and d_seen are 0, every event and mask register holds 0, and the control register holds 0 (live bus, concurrent, no pause).
- R2: A comparator matches when every bit of the selected source equals the event bit or has its mask bit set to 1 (a set mask bit is ignored). Host writes use wr_addr 0 first event, 1 first mask, 2 second event, 3 second mask, 4 pause event, 5 pause mask, 6 emulation value, 7 control.
- R3: Control register bits: [0] source is emulation register, [1] sequential mode, [2] conditional pause enable, [3] unconditional pause. These bits are stored on a write to address 7. Bit 4 of that write is an arm command, and bit 5 is a clear command that takes priority over arm. Neither command bit is stored.
- R4: In concurrent mode, while armed, trig_pulse is 1 in the cycle after the edge at which the source matches both the first and second conditions.
- R5: In sequential mode, a first-condition match while armed sets d_seen at the next edge. A trigger needs a second-condition match at a later edge while d_seen is 1. A second-condition match seen before d_seen is set has no effect. A value matching both conditions sets d_seen first and triggers one edge later if it persists.
- R6: trig_pulse lasts exactly one cycle. The same edge clears armed and d_seen, and no further pulse occurs until an arm command.
- R7: An arm command sets armed and clears d_seen at its edge. A clear command clears armed and d_seen at its edge, and nothing triggers until the unit is armed again.
- R8: With control bit 0 set, the emulation register is the source and the live bus has no effect. With bit 0 clear, a live bus value present at an edge reaches trig_pulse at the third edge (two synchroniser stages and the trigger register). An emulation write reaches trig_pulse at the next edge.
- R9: With conditional pause enabled, pause is 1 in the cycle after an edge at which run is 1 and the source matches the pause condition.
- R10: With unconditional pause set, pause is 1 in the cycle after any edge at which run is 1. pause is 0 after any edge at which run is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_bus | input | 16 | Live external event bus, asynchronous |
| run | input | 1 | Sequencer is running |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 16 | Host write data |
| trig_pulse | output | 1 | One-cycle start trigger |
| pause | output | 1 | Pause request level |
| armed | output | 1 | Unit armed and awaiting trigger |
| d_seen | output | 1 | First condition seen in sequential mode |

## Verification
On every cycle, the embedded assertions check these properties:
- the trigger is a single cycle wide and is only produced from an armed state;
- a sequential trigger always follows a recorded first-condition match;
- a clear command empties the arming state;
- pause never appears without run, and the unconditional pause follows run.

Only the bench's scenarios can show the rest. That covers the masked comparison over a wide sweep of event, mask and source values, the synchroniser latency of the live path, the ordering rules of sequential mode, and the fact that the live bus is ignored while the emulation register is selected.

// File: rtl/evt_trigger_unit.sv
module evt_trigger_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_bus,
  input  logic         run,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         trig_pulse,
  output logic         pause,
  output logic         armed,
  output logic         d_seen
);

  localparam logic [2:0] A_DEV  = 3'd0;
  localparam logic [2:0] A_DMK  = 3'd1;
  localparam logic [2:0] A_TEV  = 3'd2;
  localparam logic [2:0] A_TMK  = 3'd3;
  localparam logic [2:0] A_PEV  = 3'd4;
  localparam logic [2:0] A_PMK  = 3'd5;
  localparam logic [2:0] A_EMU  = 3'd6;
  localparam logic [2:0] A_CTRL = 3'd7;

  logic [W-1:0] d_ev, d_mk, t_ev, t_mk, p_ev, p_mk, emu;
  logic [W-1:0] sync1, sync2, src;
  logic         src_emu, seq_q, pen_q, punc_q;
  logic         d_hit, t_hit, p_hit, fire;
  logic         ctrl_wr, cmd_clr, cmd_arm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= evt_bus;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      d_ev <= '0; d_mk <= '0;
      t_ev <= '0; t_mk <= '0;
      p_ev <= '0; p_mk <= '0;
      emu  <= '0;
      src_emu <= 1'b0; seq_q <= 1'b0; pen_q <= 1'b0; punc_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_DEV:  d_ev <= wr_data;
        A_DMK:  d_mk <= wr_data;
        A_TEV:  t_ev <= wr_data;
        A_TMK:  t_mk <= wr_data;
        A_PEV:  p_ev <= wr_data;
        A_PMK:  p_mk <= wr_data;
        A_EMU:  emu  <= wr_data;
        A_CTRL: begin
          src_emu <= wr_data[0];
          seq_q   <= wr_data[1];
          pen_q   <= wr_data[2];
          punc_q  <= wr_data[3];
        end
        default: ;
      endcase
    end

  assign src     = src_emu ? emu : sync2;
  assign d_hit   = &((src ~^ d_ev) | d_mk);
  assign t_hit   = &((src ~^ t_ev) | t_mk);
  assign p_hit   = &((src ~^ p_ev) | p_mk);
  assign fire    = armed && t_hit && (seq_q ? d_seen : d_hit);

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign cmd_clr = ctrl_wr && wr_data[5];
  assign cmd_arm = ctrl_wr && wr_data[4] && !wr_data[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed      <= 1'b0;
      d_seen     <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      trig_pulse <= 1'b0;
      if (cmd_clr) begin
        armed  <= 1'b0;
        d_seen <= 1'b0;
      end else if (cmd_arm) begin
        armed  <= 1'b1;
        d_seen <= 1'b0;
      end else if (fire) begin
        trig_pulse <= 1'b1;
        armed      <= 1'b0;
        d_seen     <= 1'b0;
      end else if (armed && seq_q && d_hit && !d_seen) begin
        d_seen <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pause <= 1'b0;
    else        pause <= run && (punc_q || (pen_q && p_hit));

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  a_r6_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (!armed && !d_seen));

  a_r7_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(armed));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_data[5]) |=> (!armed && !d_seen));

  a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(seq_q)) |-> $past(d_seen));

  a_r10_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> $past(run));

  a_r10_uncond: assert property (@(posedge clk) disable iff (!rst_n)
    (run && punc_q) |=> pause);

endmodule

// File: tb/tb_evt_trigger_unit.sv
module tb_evt_trigger_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] evt_bus = '0;
  logic         run = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         trig_pulse, pause, armed, d_seen;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  evt_trigger_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .evt_bus(evt_bus), .run(run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_pulse(trig_pulse), .pause(pause), .armed(armed), .d_seen(d_seen)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [W-1:0] mix(input int i);
    logic [31:0] v;
    v = i * 32'h9E3779B1;
    v = v ^ (v >> 15) ^ (v << 7);
    return v[W-1:0];
  endfunction

  function automatic logic hit(input logic [W-1:0] s, e, m);
    for (int b = 0; b < W; b++)
      if (!m[b] && (s[b] != e[b])) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] dev, dmk, tev, tmk, x, pev, pmk;
    logic e;
    @(negedge clk); @(negedge clk);
    check("R1 trig", trig_pulse, 0);
    check("R1 pause", pause, 0);
    check("R1 armed", armed, 0);
    rst_n = 1'b1;
    step();
    check("R1 d_seen", d_seen, 0);
    run = 1'b1; step();
    check("R1 no pause by default", pause, 0);
    run = 1'b0;

    // R2 R4: concurrent sweep from the emulation register
    for (int i = 0; i < 256; i++) begin
      dev = mix(i);
      dmk = mix(i + 1000) & mix(i + 2000);
      x   = (i % 3 == 0) ? dev : dev ^ (mix(i + 3000) & mix(i + 3500));
      tev = (i % 2 == 0) ? x : mix(i + 4000);
      tmk = mix(i + 5000) & mix(i + 6000) & mix(i + 7000);
      wr(3'd7, 16'h0021);
      wr(3'd0, dev); wr(3'd1, dmk); wr(3'd2, tev); wr(3'd3, tmk);
      wr(3'd6, x);
      wr(3'd7, 16'h0011);
      step();
      e = hit(x, dev, dmk) && hit(x, tev, tmk);
      check("R2 R4 concurrent match", trig_pulse, e);
      check("R6 armed after", armed, !e);
    end

    // R8: live bus ignored with emulation source; R6 R7 single shot
    wr(3'd7, 16'h0021);
    wr(3'd0, 16'hABCD); wr(3'd1, 16'h0000);
    wr(3'd2, 16'hABCD); wr(3'd3, 16'h0000);
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0011);
    evt_bus = 16'hABCD;
    step(); step(); step();
    check("R8 live bus ignored trig", trig_pulse, 0);
    check("R8 live bus ignored armed", armed, 1);
    wr(3'd6, 16'hABCD);
    step();
    check("R8 emu path latency", trig_pulse, 1);
    step();
    check("R6 one cycle", trig_pulse, 0);
    check("R6 disarmed", armed, 0);
    step(); step();
    check("R7 no retrigger until armed", trig_pulse, 0);
    wr(3'd7, 16'h0011);
    step();
    check("R7 rearm triggers", trig_pulse, 1);

    // R8: live path latency, three edges
    evt_bus = 16'h0000;
    wr(3'd7, 16'h0020); step(); step();
    wr(3'd7, 16'h0010);
    evt_bus = 16'hABCD;
    step();
    check("R8 live edge1", trig_pulse, 0);
    step();
    check("R8 live edge2", trig_pulse, 0);
    step();
    check("R8 live edge3", trig_pulse, 1);
    evt_bus = 16'h0000;

    // R5: sequential ordering
    wr(3'd7, 16'h0023);
    wr(3'd0, 16'h00F0); wr(3'd1, 16'hFF00);
    wr(3'd2, 16'h0F00); wr(3'd3, 16'h00FF);
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0013);
    step();
    check("R5 idle no trig", trig_pulse, 0);
    check("R5 idle d_seen", d_seen, 0);
    wr(3'd6, 16'h55F0);
    step();
    check("R5 first sets d_seen", d_seen, 1);
    check("R5 first no trig", trig_pulse, 0);
    wr(3'd6, 16'h0F33);
    step();
    check("R5 second triggers", trig_pulse, 1);
    step();
    check("R6 seq one cycle", trig_pulse, 0);
    check("R6 seq disarmed", armed, 0);

    wr(3'd7, 16'h0023);
    wr(3'd6, 16'h0FF0);
    wr(3'd7, 16'h0013);
    step();
    check("R5 both: d_seen first", d_seen, 1);
    check("R5 both: no trig yet", trig_pulse, 0);
    step();
    check("R5 both: trig one later", trig_pulse, 1);

    wr(3'd7, 16'h0023);
    wr(3'd6, 16'h0F00);
    wr(3'd7, 16'h0013);
    step();
    check("R5 second before first", trig_pulse, 0);
    check("R5 second before first d_seen", d_seen, 0);
    wr(3'd6, 16'h55F0);
    step();
    check("R5 then first", d_seen, 1);
    step();
    check("R5 stale second no trig", trig_pulse, 0);

    // R7: clear empties the armed state
    wr(3'd7, 16'h0023);
    check("R7 clear armed", armed, 0);
    check("R7 clear d_seen", d_seen, 0);
    wr(3'd6, 16'h0F00);
    step();
    check("R7 cleared no trig", trig_pulse, 0);
    wr(3'd7, 16'h0033);
    check("R3 clear beats arm", armed, 0);

    // R9: conditional pause sweep
    wr(3'd7, 16'h0005);
    for (int i = 0; i < 64; i++) begin
      pev = mix(i + 9000);
      pmk = mix(i + 9100) & mix(i + 9200);
      x   = (i % 2 == 0) ? pev : pev ^ mix(i + 9300);
      run = (i % 4 != 3);
      wr(3'd4, pev); wr(3'd5, pmk); wr(3'd6, x);
      step();
      check("R9 conditional pause", pause, run && hit(x, pev, pmk));
    end

    // R10: unconditional pause follows run
    wr(3'd7, 16'h0009);
    wr(3'd6, 16'h0000); wr(3'd4, 16'hFFFF); wr(3'd5, 16'h0000);
    run = 1'b1; step();
    check("R10 uncond with run", pause, 1);
    run = 1'b0; step();
    check("R10 no run no pause", pause, 0);
    run = 1'b1; step();
    check("R10 uncond again", pause, 1);
    wr(3'd7, 16'h0001);
    step();
    check("R10 pause off", pause, 0);
    run = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule